// File: doc/BRIEF.md
# Sound Generator Command Register Interface

This block is the byte-wide write port and register file of a four-channel programmable sound generator. A host places a byte on an 8-bit bus and pulls an active-low write strobe. The strobe passes through a two-flop synchroniser, and each falling edge of the synchronised copy causes exactly one byte to be decoded. The block holds three 10-bit tone periods, four 4-bit attenuation values and a 3-bit noise control field. It drives them continuously to the tone, noise and volume datapaths.

A byte can take one of two forms. A latch byte has bit 7 set. It names a channel (bits 6..5) and a register kind (bit 4: 0 = period or noise control, 1 = attenuation), and it writes its low bits into that register at once. A data byte has bit 7 clear. It updates whichever register the last latch byte selected. For a tone period it fills the upper six bits; for an attenuation or the noise control it replaces the value with its low bits. Any write to the noise control arms a restart. A one-cycle restart pulse then goes to the noise generator once the strobe has returned high.

Top module: `psg_cmd_regs`

## Requirements
- R1: While reset is asserted and directly after it, every attenuation is 15 and every tone period is 0. The noise control is 0, no restart pulse is raised, and the selection is channel 0, period kind.
- R2: A latch byte 1cc0dddd with cc in 0..2 writes dddd into bits 3..0 of period cc and leaves bits 9..4 unchanged.
- R3: A data byte 0xdddddd, when the last latch selected period kind on channel 0..2, writes its bits 5..0 into bits 9..4 of that period and leaves bits 3..0 unchanged.
- R4: A latch byte 1cc1aaaa writes aaaa into the attenuation of channel cc. Channel 3 is the noise channel.
- R5: A latch byte 11100bff, or a data byte that follows it, writes bits 2..0 into the noise control. Bit 2 is the white/periodic select and bits 1..0 are the rate source.
- R6: A data byte that follows an attenuation latch writes its bits 3..0 into that same channel's attenuation.
- R7: A strobe held low acts once. Bus changes made while the strobe stays low have no effect.
- R8: After a write to the noise control, noise_restart is high for exactly one cycle, three clock edges after the strobe returns high. Writes to other registers raise no pulse.
- R9: A register update becomes visible three clock edges after the strobe falls and is not visible after two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single-phase clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_n | input | 1 | Write strobe, active low, asynchronous to clk |
| bus_data | input | 8 | Command byte, stable while wr_n is low |
| tone_period | output | 30 | Three 10-bit periods, channel 0 in bits 9..0 |
| atten_level | output | 16 | Four 4-bit attenuations, channel 0 in bits 3..0 |
| noise_ctrl | output | 3 | Noise select (bit 2) and rate source (bits 1..0) |
| noise_restart | output | 1 | One-cycle noise generator restart pulse |

## Verification
Two flops synchronise the strobe and a third records its previous value. Register outputs therefore change on the third rising edge after a strobe driven low at a falling clock edge, and the restart pulse appears on the third edge after the strobe is driven high. The bench drives inputs at falling edges and samples at falling edges. It checks that nothing has changed after the second edge, that the new state is present after the third, and that the restart pulse is high after the third edge following the release and low after the fourth. Each write then ends with one idle cycle, so that the previous-value flop is back high before the next falling strobe.

// File: rtl/psg_cmd_pkg.sv
package psg_cmd_pkg;

    localparam int NUM_TONE = 3;
    localparam int NUM_CH   = 4;
    localparam int PER_W    = 10;
    localparam int PER_LO_W = 4;
    localparam int PER_HI_W = PER_W - PER_LO_W;
    localparam int ATT_W    = 4;
    localparam int NZ_W     = 3;
    localparam int CH_W     = $clog2(NUM_CH);
    localparam int NOISE_CH = NUM_CH - 1;

    typedef enum logic {
        KIND_PERIOD = 1'b0,
        KIND_ATTEN  = 1'b1
    } reg_kind_e;

    typedef struct packed {
        logic [CH_W-1:0] ch;
        reg_kind_e       kind;
    } sel_t;

    typedef struct packed {
        logic                tone_lo;
        logic                tone_hi;
        logic                att;
        logic                noise;
        logic [CH_W-1:0]     ch;
        logic [PER_HI_W-1:0] payload;
        sel_t                sel_next;
    } wr_cmd_t;

endpackage

// File: rtl/psg_strobe_sync.sv
module psg_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic wr_n,
    output logic fall_o,
    output logic rise_o
);
    localparam int CHAIN = STAGES + 1;

    logic [CHAIN-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[CHAIN-2:0], wr_n};
    end

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '1;
        else     sh_q <= sh_d;
    end

    assign fall_o = !sh_q[STAGES-1] &&  sh_q[STAGES];
    assign rise_o =  sh_q[STAGES-1] && !sh_q[STAGES];
endmodule

// File: rtl/psg_cmd_decode.sv
module psg_cmd_decode
    import psg_cmd_pkg::*;
(
    input  logic       strobe,
    input  logic [7:0] byte_i,
    input  sel_t       sel_q,
    output wr_cmd_t    cmd_o
);
    logic            is_latch;
    logic [CH_W-1:0] ch;
    reg_kind_e       kind;

    always_comb begin
        is_latch = byte_i[7];
        if (is_latch) begin
            ch   = byte_i[6:5];
            kind = reg_kind_e'(byte_i[4]);
        end else begin
            ch   = sel_q.ch;
            kind = sel_q.kind;
        end

        cmd_o               = '0;
        cmd_o.ch            = ch;
        cmd_o.sel_next      = sel_q;
        cmd_o.payload       = is_latch ? {{(PER_HI_W-PER_LO_W){1'b0}}, byte_i[3:0]}
                                       : byte_i[PER_HI_W-1:0];
        if (strobe) begin
            if (is_latch) begin
                cmd_o.sel_next.ch   = ch;
                cmd_o.sel_next.kind = kind;
            end
            if (kind == KIND_ATTEN) begin
                cmd_o.att = 1'b1;
            end else if (int'(ch) == NOISE_CH) begin
                cmd_o.noise = 1'b1;
            end else if (is_latch) begin
                cmd_o.tone_lo = 1'b1;
            end else begin
                cmd_o.tone_hi = 1'b1;
            end
        end
    end
endmodule

// File: rtl/psg_reg_file.sv
module psg_reg_file
    import psg_cmd_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  wr_cmd_t cmd_i,
    input  logic    rise_i,
    output sel_t    sel_o,
    output logic [NUM_TONE-1:0][PER_W-1:0] tone_o,
    output logic [NUM_CH-1:0][ATT_W-1:0]   att_o,
    output logic [NZ_W-1:0]                noise_o,
    output logic                           restart_o
);
    typedef struct packed {
        logic [NUM_TONE-1:0][PER_W-1:0] tone;
        logic [NUM_CH-1:0][ATT_W-1:0]   att;
        logic [NZ_W-1:0]                noise;
        sel_t                           sel;
        logic                           pend;
        logic                           restart;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.restart = 1'b0;
        st_d.sel     = cmd_i.sel_next;

        for (int i = 0; i < NUM_TONE; i++) begin
            if (int'(cmd_i.ch) == i) begin
                if (cmd_i.tone_lo)
                    st_d.tone[i][PER_LO_W-1:0] = cmd_i.payload[PER_LO_W-1:0];
                if (cmd_i.tone_hi)
                    st_d.tone[i][PER_W-1:PER_LO_W] = cmd_i.payload;
            end
        end
        for (int c = 0; c < NUM_CH; c++) begin
            if (cmd_i.att && int'(cmd_i.ch) == c)
                st_d.att[c] = cmd_i.payload[ATT_W-1:0];
        end
        if (cmd_i.noise) begin
            st_d.noise = cmd_i.payload[NZ_W-1:0];
            st_d.pend  = 1'b1;
        end
        if (rise_i && st_q.pend) begin
            st_d.restart = 1'b1;
            st_d.pend    = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.tone    <= '0;
            st_q.att     <= '1;
            st_q.noise   <= '0;
            st_q.sel     <= '{ch: '0, kind: KIND_PERIOD};
            st_q.pend    <= 1'b0;
            st_q.restart <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sel_o     = st_q.sel;
    assign tone_o    = st_q.tone;
    assign att_o     = st_q.att;
    assign noise_o   = st_q.noise;
    assign restart_o = st_q.restart;
endmodule

// File: rtl/psg_cmd_regs.sv
module psg_cmd_regs
    import psg_cmd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_n,
    input  logic [7:0]                bus_data,
    output logic [NUM_TONE*PER_W-1:0] tone_period,
    output logic [NUM_CH*ATT_W-1:0]   atten_level,
    output logic [NZ_W-1:0]           noise_ctrl,
    output logic                      noise_restart
);
    logic    fall, rise;
    sel_t    sel;
    wr_cmd_t cmd;
    logic [NUM_TONE-1:0][PER_W-1:0] tone_w;
    logic [NUM_CH-1:0][ATT_W-1:0]   att_w;

    psg_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .wr_n(wr_n), .fall_o(fall), .rise_o(rise)
    );

    psg_cmd_decode u_dec (
        .strobe(fall), .byte_i(bus_data), .sel_q(sel), .cmd_o(cmd)
    );

    psg_reg_file u_regs (
        .clk(clk), .rst(rst), .cmd_i(cmd), .rise_i(rise), .sel_o(sel),
        .tone_o(tone_w), .att_o(att_w), .noise_o(noise_ctrl),
        .restart_o(noise_restart)
    );

    assign tone_period = tone_w;
    assign atten_level = att_w;
endmodule

// File: rtl/psg_cmd_checker.sv
module psg_cmd_checker
    import psg_cmd_pkg::*;
(
    input logic                      clk,
    input logic                      rst,
    input logic                      wr_n,
    input logic [NUM_TONE*PER_W-1:0] tone_period,
    input logic [NUM_CH*ATT_W-1:0]   atten_level,
    input logic [NZ_W-1:0]           noise_ctrl,
    input logic                      noise_restart
);
    // R1: state directly after a reset cycle
    assert_reset_state_R1: assert property (@(posedge clk)
        $past(rst) |-> (atten_level == '1 && tone_period == '0 &&
                        noise_ctrl == '0 && !noise_restart));

    // R9: a register change only follows a strobe fall seen three edges earlier
    assert_update_latency_R9: assert property (@(posedge clk) disable iff (rst)
        (!$stable(tone_period) || !$stable(atten_level) || !$stable(noise_ctrl))
        |-> (!$past(wr_n, 3) && $past(wr_n, 4)));

    // R8: restart pulse is one cycle wide
    assert_restart_width_R8: assert property (@(posedge clk) disable iff (rst)
        noise_restart |=> !noise_restart);

    // R8: restart pulse only follows a strobe release
    assert_restart_timing_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(noise_restart) |-> ($past(wr_n, 3) && !$past(wr_n, 4)));
endmodule

bind psg_cmd_regs psg_cmd_checker u_chk (
    .clk(clk), .rst(rst), .wr_n(wr_n), .tone_period(tone_period),
    .atten_level(atten_level), .noise_ctrl(noise_ctrl),
    .noise_restart(noise_restart)
);

// File: tb/tb_psg_cmd_regs.sv
module tb_psg_cmd_regs;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_n = 1'b1;
    logic [7:0]  bus_data = 8'h00;
    logic [29:0] tone_period;
    logic [15:0] atten_level;
    logic [2:0]  noise_ctrl;
    logic        noise_restart;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // expected model
    logic [9:0] m_tone [3];
    logic [3:0] m_att  [4];
    logic [2:0] m_noise;
    logic [1:0] m_ch;
    logic       m_kind;
    logic       m_nz_hit;
    string      m_tag;

    always #2.5 clk = ~clk;

    psg_cmd_regs dut (
        .clk(clk), .rst(rst), .wr_n(wr_n), .bus_data(bus_data),
        .tone_period(tone_period), .atten_level(atten_level),
        .noise_ctrl(noise_ctrl), .noise_restart(noise_restart)
    );

    function automatic logic [29:0] exp_tone();
        return {m_tone[2], m_tone[1], m_tone[0]};
    endfunction
    function automatic logic [15:0] exp_att();
        return {m_att[3], m_att[2], m_att[1], m_att[0]};
    endfunction

    task automatic model_apply(input logic [7:0] b);
        logic [1:0] ch;
        logic kind;
        m_nz_hit = 1'b0;
        if (b[7]) begin ch = b[6:5]; kind = b[4]; m_ch = ch; m_kind = kind; end
        else begin ch = m_ch; kind = m_kind; end
        if (kind) begin
            m_att[ch] = b[3:0];
            m_tag = b[7] ? "R4" : "R6";
        end else if (ch == 2'd3) begin
            m_noise = b[2:0];
            m_nz_hit = 1'b1;
            m_tag = "R5";
        end else if (b[7]) begin
            m_tone[ch][3:0] = b[3:0];
            m_tag = "R2";
        end else begin
            m_tone[ch][9:4] = b[5:0];
            m_tag = "R3";
        end
    endtask

    task automatic check_state(input string tag);
        checks++;
        if (tone_period !== exp_tone() || atten_level !== exp_att() ||
            noise_ctrl !== m_noise) begin
            errors++;
            $display("FAIL %s: tone=%h att=%h noise=%h expected tone=%h att=%h noise=%h",
                     tag, tone_period, atten_level, noise_ctrl,
                     exp_tone(), exp_att(), m_noise);
        end
    endtask

    task automatic check_bit(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    // hold >= 3; if alt_en the bus changes to alt while the strobe stays low
    task automatic do_write(input logic [7:0] b, input int hold,
                            input bit alt_en, input logic [7:0] alt);
        @(negedge clk);
        bus_data = b;
        wr_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check_state("R9");              // two edges: not yet visible
        model_apply(b);
        @(negedge clk);
        check_state(m_tag);             // third edge: visible (R9)
        if (alt_en) bus_data = alt;
        for (int i = 3; i < hold; i++) @(negedge clk);
        wr_n = 1'b1;
        if (alt_en) check_state("R7");
        @(negedge clk);
        @(negedge clk);
        check_bit("R8", noise_restart, 1'b0);
        @(negedge clk);
        check_bit("R8", noise_restart, m_nz_hit);
        if (alt_en) check_state("R7");
        @(negedge clk);
        check_bit("R8", noise_restart, 1'b0);
    endtask

    initial begin
        for (int i = 0; i < 3; i++) m_tone[i] = '0;
        for (int i = 0; i < 4; i++) m_att[i] = 4'hF;
        m_noise = '0; m_ch = '0; m_kind = 1'b0; m_nz_hit = 1'b0;
        void'($urandom(32'h5eed_1234));

        repeat (4) @(negedge clk);
        check_state("R1");
        check_bit("R1", noise_restart, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        check_state("R1");
        check_bit("R1", noise_restart, 1'b0);

        // data byte right after reset goes to channel 0 period high bits (R1, R3)
        do_write(8'h2A, 3, 0, 8'h00);
        // the 440 Hz style sequence: period 0x11C on channel 0
        do_write(8'h8C, 3, 0, 8'h00);   // R2
        do_write(8'h11, 4, 0, 8'h00);   // R3
        do_write(8'h90, 3, 0, 8'h00);   // R4
        do_write(8'hE4, 3, 0, 8'h00);   // R5 noise latch, restart pulse
        do_write(8'h03, 3, 0, 8'h00);   // R5 data after noise latch
        do_write(8'hF8, 3, 0, 8'h00);   // R4 channel 3 attenuation
        do_write(8'h05, 3, 0, 8'h00);   // R6 data after attenuation latch
        do_write(8'hDF, 3, 0, 8'h00);   // R4 channel 2
        do_write(8'hC3, 3, 0, 8'h00);   // R2 channel 2 low nibble
        do_write(8'h3F, 3, 0, 8'h00);   // R3 channel 2 high bits all ones
        // R7: long strobe with the bus changing to other writes meanwhile
        do_write(8'hA7, 9, 1, 8'hB0);
        do_write(8'hE7, 8, 1, 8'h9C);

        for (int n = 0; n < 300; n++) begin
            logic [7:0] b;
            b = 8'($urandom);
            do_write(b, 3 + int'($urandom % 4), ($urandom % 8) == 0, 8'($urandom));
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule